// File: doc/BRIEF.md
# Banked Level-Sensitive Interrupt Controller

The block gathers 8 basic interrupt sources and two banks of 32 peripheral sources. It presents them to software through a small register port and drives one interrupt request line to the processor. Every source is level-sensitive. A source is reported while its input is high and its enable bit is set. Each bank holds one enable mask. Software sets mask bits through a write-one-to-set offset and clears them through a write-one-to-clear offset.

The basic pending word gives a handler a fast first look. Its low 8 bits are the basic sources. Two summary bits say that bank 1 or bank 2 has an enabled source that needs a second read. Eleven shortcut bits copy selected bank sources directly, so a handler can serve them from the basic word alone. A source that has a shortcut never raises its bank's summary bit. Summary and shortcut bits cannot be masked in the basic bank. They follow the enables of the bank that owns the source.

Register writes take effect at the clock edge where write strobe is high. Reads are combinational from the address.

Top module: `bank_irq_ctrl`

## Requirements
- R1: After reset all three enable masks are zero, all three pending offsets read zero and irq_o is low.
- R2: Writing to an enable offset (basic 0x18, bank 1 0x10, bank 2 0x14) sets the mask bits written as 1 and leaves the others unchanged. The enable offset and the disable offset of a bank both read back the current mask; the basic mask occupies bits 7:0.
- R3: Writing to a disable offset (basic 0x24, bank 1 0x1c, bank 2 0x20) clears the mask bits written as 1 and leaves the others unchanged.
- R4: Bank pending offsets (bank 1 at 0x04, bank 2 at 0x08) read the raw inputs ANDed with that bank's mask, and a bit follows the input level for as long as it is enabled.
- R5: Bits 7:0 of the basic pending word at 0x00 equal the basic inputs ANDed with the basic mask.
- R6: Basic pending bit 8 (bank 1) or bit 9 (bank 2) is set exactly when that bank has an enabled pending source that has no shortcut.
- R7: Bank 1 sources 7, 9, 10, 18, 19 appear at basic pending bits 10 to 14 in that order; bank 2 sources 21, 22, 23, 24, 25, 30 appear at bits 15 to 20 in that order, each equal to the enabled pending state of its source.
- R8: A pending shortcut source sets its own bank pending bit and its shortcut bit but never the summary bit, even when it is the only pending source in its bank.
- R9: Writes to basic enable or disable bits 31:8 have no effect on any mask or pending bit.
- R10: Basic pending bits 31:21 read zero, and irq_o is high exactly when any basic pending bit 20:0 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| basic_src_i | input | 8 | Basic interrupt source levels |
| bank1_src_i | input | 32 | Bank 1 source levels |
| bank2_src_i | input | 32 | Bank 2 source levels |
| addr_i | input | 6 | Register byte address |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe |
| rdata_o | output | 32 | Read data for addr_i |
| irq_o | output | 1 | Interrupt request to processor |

## Verification
The only state is the three enable masks. A corrupted mask bit shows up on the next read of either of its two offsets. It also shows up on the same cycle in the pending words and irq_o whenever the matching source is high. A misplaced shortcut index or a wrong shortcut mask leaves the bank pending word unchanged. The error then appears only in the basic word, as a wrong shortcut position or a summary bit that is raised or left clear wrongly. For this reason the random sources are kept sparse, so that a bank often holds only shortcut sources.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int BASIC_N  = 8;
  localparam int BANK_W   = 32;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 6;
  localparam int N_BANKS  = 2;
  localparam int SUM_BASE = 8;
  localparam int SC_BASE  = 10;
  localparam int SC_N0    = 5;
  localparam int SC_N1    = 6;
  localparam int LIVE_W   = SC_BASE + SC_N0 + SC_N1;

  localparam logic [ADDR_W-1:0] OFF_PEND0 = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_PEND1 = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_PEND2 = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_EN1   = 6'h10;
  localparam logic [ADDR_W-1:0] OFF_EN2   = 6'h14;
  localparam logic [ADDR_W-1:0] OFF_EN0   = 6'h18;
  localparam logic [ADDR_W-1:0] OFF_DIS1  = 6'h1c;
  localparam logic [ADDR_W-1:0] OFF_DIS2  = 6'h20;
  localparam logic [ADDR_W-1:0] OFF_DIS0  = 6'h24;

  // b: 0 = bank 1, 1 = bank 2
  function automatic int sc_count(int b);
    return (b == 0) ? SC_N0 : SC_N1;
  endfunction

  function automatic int sc_src(int b, int k);
    int r;
    r = 0;
    if (b == 0) begin
      case (k)
        0: r = 7;
        1: r = 9;
        2: r = 10;
        3: r = 18;
        default: r = 19;
      endcase
    end else begin
      case (k)
        0: r = 21;
        1: r = 22;
        2: r = 23;
        3: r = 24;
        4: r = 25;
        default: r = 30;
      endcase
    end
    return r;
  endfunction

  function automatic logic [BANK_W-1:0] sc_mask(int b);
    logic [BANK_W-1:0] m;
    m = '0;
    for (int k = 0; k < sc_count(b); k++) m[sc_src(b, k)] = 1'b1;
    return m;
  endfunction

  function automatic int sc_pos(int b);
    return (b == 0) ? SC_BASE : SC_BASE + SC_N0;
  endfunction

  function automatic logic [ADDR_W-1:0] off_en(int b);
    return (b == 0) ? OFF_EN1 : OFF_EN2;
  endfunction

  function automatic logic [ADDR_W-1:0] off_dis(int b);
    return (b == 0) ? OFF_DIS1 : OFF_DIS2;
  endfunction
endpackage

// File: rtl/irqc_mask_reg.sv
module irqc_mask_reg #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q;
  logic [W-1:0] set_bits, clr_bits;

  assign set_bits = set_i ? data_i : '0;
  assign clr_bits = clr_i ? data_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else if (set_i || clr_i) mask_q <= (mask_q | set_bits) & ~clr_bits;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/irqc_shortcut_fold.sv
module irqc_shortcut_fold
  import irqc_pkg::*;
#(
  parameter int BANK = 0,
  parameter int NSC  = 5
) (
  input  logic [BANK_W-1:0] pend_i,
  output logic [NSC-1:0]    sc_o,
  output logic              summary_o
);
  localparam logic [BANK_W-1:0] SC_MASK = sc_mask(BANK);

  for (genvar k = 0; k < NSC; k++) begin : g_sc
    assign sc_o[k] = pend_i[sc_src(BANK, k)];
  end

  // shortcut sources never reach the summary bit
  assign summary_o = |(pend_i & ~SC_MASK);
endmodule

// File: rtl/irqc_read_mux.sv
module irqc_read_mux
  import irqc_pkg::*;
(
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  pend0_i,
  input  logic [BANK_W-1:0]  pend1_i,
  input  logic [BANK_W-1:0]  pend2_i,
  input  logic [BASIC_N-1:0] en0_i,
  input  logic [BANK_W-1:0]  en1_i,
  input  logic [BANK_W-1:0]  en2_i,
  output logic [DATA_W-1:0]  rdata_o
);
  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFF_PEND0:          rdata_o = pend0_i;
      OFF_PEND1:          rdata_o = pend1_i;
      OFF_PEND2:          rdata_o = pend2_i;
      OFF_EN0, OFF_DIS0:  rdata_o = {{(DATA_W-BASIC_N){1'b0}}, en0_i};
      OFF_EN1, OFF_DIS1:  rdata_o = en1_i;
      OFF_EN2, OFF_DIS2:  rdata_o = en2_i;
      default:            rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/bank_irq_ctrl.sv
module bank_irq_ctrl
  import irqc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        basic_src_i,
  input  logic [31:0]       bank1_src_i,
  input  logic [31:0]       bank2_src_i,
  input  logic [5:0]        addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              we_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o
);
  logic [BASIC_N-1:0] en0_q;
  logic [BASIC_N-1:0] basic_pend;
  logic [BANK_W-1:0]  bank_src  [N_BANKS];
  logic [BANK_W-1:0]  bank_en   [N_BANKS];
  logic [BANK_W-1:0]  bank_pend [N_BANKS];
  logic [LIVE_W-1:0]  live_word;
  logic [DATA_W-1:0]  pend0_word;

  assign bank_src[0] = bank1_src_i;
  assign bank_src[1] = bank2_src_i;

  // basic mask only covers the basic sources; upper write bits are dropped
  irqc_mask_reg #(.W(BASIC_N)) u_en0 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (we_i && addr_i == OFF_EN0),
    .clr_i  (we_i && addr_i == OFF_DIS0),
    .data_i (wdata_i[BASIC_N-1:0]),
    .mask_o (en0_q)
  );

  assign basic_pend = basic_src_i & en0_q;
  assign live_word[BASIC_N-1:0] = basic_pend;

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    localparam int NSC = sc_count(b);
    logic [NSC-1:0] sc;
    logic           summary;

    irqc_mask_reg #(.W(BANK_W)) u_en (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (we_i && addr_i == off_en(b)),
      .clr_i  (we_i && addr_i == off_dis(b)),
      .data_i (wdata_i),
      .mask_o (bank_en[b])
    );

    assign bank_pend[b] = bank_src[b] & bank_en[b];

    irqc_shortcut_fold #(.BANK(b), .NSC(NSC)) u_fold (
      .pend_i    (bank_pend[b]),
      .sc_o      (sc),
      .summary_o (summary)
    );

    assign live_word[SUM_BASE+b]       = summary;
    assign live_word[sc_pos(b) +: NSC] = sc;
  end

  assign pend0_word = {{(DATA_W-LIVE_W){1'b0}}, live_word};
  assign irq_o      = |live_word;

  irqc_read_mux u_rd (
    .addr_i  (addr_i),
    .pend0_i (pend0_word),
    .pend1_i (bank_pend[0]),
    .pend2_i (bank_pend[1]),
    .en0_i   (en0_q),
    .en1_i   (bank_en[0]),
    .en2_i   (bank_en[1]),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/bank_irq_ctrl_chk.sv
module bank_irq_ctrl_chk
  import irqc_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic [7:0]  basic_src_i,
  input logic [31:0] bank1_src_i,
  input logic [31:0] bank2_src_i,
  input logic [5:0]  addr_i,
  input logic [31:0] wdata_i,
  input logic        we_i,
  input logic [31:0] rdata_o,
  input logic        irq_o,
  input logic [7:0]  en0_q,
  input logic [31:0] en1_q,
  input logic [31:0] en2_q
);
  localparam logic [31:0] SC1 = sc_mask(0);

  AST_EN1_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i == OFF_EN1 |=> (en1_q & $past(wdata_i)) == $past(wdata_i)); // R2
  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(en0_q) && $stable(en1_q) && $stable(en2_q)); // R2
  AST_DIS2_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i == OFF_DIS2 |=> (en2_q & $past(wdata_i)) == '0); // R3
  AST_BANK1_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == OFF_PEND1 |-> rdata_o == (bank1_src_i & en1_q)); // R4
  AST_SC_NO_SUMMARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == OFF_PEND0 && (bank1_src_i & en1_q & ~SC1) == '0 |-> !rdata_o[8]); // R8
  AST_BASIC_HI_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && (addr_i == OFF_EN0 || addr_i == OFF_DIS0) && wdata_i[7:0] == '0
    |=> $stable(en0_q)); // R9
  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    basic_src_i == '0 && bank1_src_i == '0 && bank2_src_i == '0 |-> !irq_o); // R10
  AST_PEND0_HI_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == OFF_PEND0 |-> rdata_o[31:21] == '0); // R10
endmodule

bind bank_irq_ctrl bank_irq_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .basic_src_i (basic_src_i),
  .bank1_src_i (bank1_src_i),
  .bank2_src_i (bank2_src_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .we_i        (we_i),
  .rdata_o     (rdata_o),
  .irq_o       (irq_o),
  .en0_q       (en0_q),
  .en1_q       (bank_en[0]),
  .en2_q       (bank_en[1])
);

// File: tb/tb_bank_irq_ctrl.sv
module tb_bank_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  basic_src_i = '0;
  logic [31:0] bank1_src_i = '0;
  logic [31:0] bank2_src_i = '0;
  logic [5:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int n_vec = 0;
  int n_bad = 0;
  logic [7:0]  m_en0 = '0;
  logic [31:0] m_en1 = '0;
  logic [31:0] m_en2 = '0;

  always #2.5 clk = ~clk;

  bank_irq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .basic_src_i(basic_src_i),
    .bank1_src_i(bank1_src_i), .bank2_src_i(bank2_src_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .we_i(we_i),
    .rdata_o(rdata_o), .irq_o(irq_o)
  );

  function automatic int sc_b1(int k);
    case (k) 0: return 7; 1: return 9; 2: return 10; 3: return 18; default: return 19; endcase
  endfunction
  function automatic int sc_b2(int k);
    case (k) 0: return 21; 1: return 22; 2: return 23; 3: return 24; 4: return 25; default: return 30; endcase
  endfunction

  function automatic logic [31:0] exp_basic();
    logic [31:0] w, p1, p2, r1, r2;
    w  = '0;
    p1 = bank1_src_i & m_en1;
    p2 = bank2_src_i & m_en2;
    r1 = p1;
    r2 = p2;
    w[7:0] = basic_src_i & m_en0;
    for (int k = 0; k < 5; k++) begin w[10+k] = p1[sc_b1(k)]; r1[sc_b1(k)] = 1'b0; end
    for (int k = 0; k < 6; k++) begin w[15+k] = p2[sc_b2(k)]; r2[sc_b2(k)] = 1'b0; end
    w[8] = |r1;
    w[9] = |r2;
    return w;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk);
    we_i = 1'b0;
    case (a)
      6'h18: m_en0 = m_en0 | d[7:0];
      6'h24: m_en0 = m_en0 & ~d[7:0];
      6'h10: m_en1 = m_en1 | d;
      6'h1c: m_en1 = m_en1 & ~d;
      6'h14: m_en2 = m_en2 | d;
      6'h20: m_en2 = m_en2 & ~d;
      default: ;
    endcase
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] v);
    addr_i = a;
    #1;
    v = rdata_o;
  endtask

  task automatic check_all(string tag);
    logic [31:0] v, e;
    e = exp_basic();
    rd(6'h00, v); chk({tag, " R5 R6 R7 R10 pend0"}, v, e);
    rd(6'h04, v); chk({tag, " R4 pend1"}, v, bank1_src_i & m_en1);
    rd(6'h08, v); chk({tag, " R4 pend2"}, v, bank2_src_i & m_en2);
    rd(6'h18, v); chk({tag, " R2 en0"}, v, {24'h0, m_en0});
    rd(6'h24, v); chk({tag, " R2 dis0 readback"}, v, {24'h0, m_en0});
    rd(6'h10, v); chk({tag, " R2 en1"}, v, m_en1);
    rd(6'h20, v); chk({tag, " R2 dis2 readback"}, v, m_en2);
    chk({tag, " R10 irq"}, {31'h0, irq_o}, {31'h0, |e[20:0]});
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1: reset state, sources high but nothing enabled
    basic_src_i = '1; bank1_src_i = '1; bank2_src_i = '1;
    rd(6'h00, v); chk("R1 pend0 after reset", v, 32'h0);
    rd(6'h04, v); chk("R1 pend1 after reset", v, 32'h0);
    rd(6'h10, v); chk("R1 en1 after reset", v, 32'h0);
    chk("R1 irq after reset", {31'h0, irq_o}, 32'h0);
    basic_src_i = '0; bank1_src_i = '0; bank2_src_i = '0;

    // R8: only a shortcut source pending in bank 1
    wr(6'h10, 32'hFFFF_FFFF);
    @(negedge clk);
    bank1_src_i = 32'h0000_0080;
    rd(6'h00, v); chk("R8 shortcut only, bit10 set bit8 clear", v, 32'h0000_0400);
    rd(6'h04, v); chk("R8 own bank bit set", v, 32'h0000_0080);
    chk("R10 irq from shortcut", {31'h0, irq_o}, 32'h1);
    // R6: non-shortcut source raises summary
    bank1_src_i = 32'h0000_0081;
    rd(6'h00, v); chk("R6 summary bit8", v, 32'h0000_0500);
    // R7: last bank 2 shortcut at bit 20
    bank1_src_i = '0;
    wr(6'h14, 32'h4000_0000);
    bank2_src_i = 32'hFFFF_FFFF;
    rd(6'h00, v); chk("R7 bank2 src30 at bit20", v, 32'h0010_0000);
    // R3: masking a shortcut in its own bank
    wr(6'h20, 32'h4000_0000);
    rd(6'h00, v); chk("R3 shortcut masked in bank", v, 32'h0);
    rd(6'h14, v); chk("R3 en2 cleared", v, 32'h0);
    // R9: basic upper bits ignored
    bank2_src_i = '0; bank1_src_i = 32'h0000_0080;
    wr(6'h18, 32'hFFFF_FF00);
    rd(6'h18, v); chk("R9 basic enable upper ignored", v, 32'h0);
    wr(6'h24, 32'h001F_FF00);
    rd(6'h00, v); chk("R9 basic disable cannot mask shortcut", v, 32'h0000_0400);
    // R2: zeros leave state unchanged
    wr(6'h18, 32'h0000_0005);
    wr(6'h18, 32'h0000_0010);
    rd(6'h18, v); chk("R2 set accumulates", v, 32'h0000_0015);
    wr(6'h24, 32'h0000_0004);
    rd(6'h18, v); chk("R3 basic clear one bit", v, 32'h0000_0011);
    check_all("directed");

    for (int i = 0; i < 400; i++) begin
      int op;
      logic [5:0] a;
      op = int'($urandom_range(0, 5));
      case (op)
        0: a = 6'h18; 1: a = 6'h10; 2: a = 6'h14;
        3: a = 6'h24; 4: a = 6'h1c; default: a = 6'h20;
      endcase
      wr(a, $urandom());
      basic_src_i = 8'($urandom());
      bank1_src_i = $urandom() & $urandom() & $urandom();
      bank2_src_i = (i % 3 == 0) ? (32'h43E0_0000 & $urandom()) : ($urandom() & $urandom());
      check_all("random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule